// File: doc/BRIEF.md
# Condition register field unit

This block holds the 32-bit condition register of an integer core, organised as eight 4-bit fields, and applies at most one update to it on each clock edge. Updates come from signed or unsigned compares that fill a chosen field, from single-bit boolean operations between any two register bits, from copies of one field into another, from a masked nibble write of a general-purpose register value, and from the outcome of a store-conditional, which is recorded in field 0.

Bits and fields are numbered from the most significant end. Bit index i sits at register position 31-i. Field f spans positions 31-4f down to 28-4f, so field 0 is the top nibble. Within a field, the first bit (the most significant one) is less-than, then greater-than, then equal, then the summary-overflow copy. The whole register is always visible on `cr_o`. `wr_fields_o` shows which fields the previous edge wrote.

Top module: `crf_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first update, `cr_o` is 0 and `wr_fields_o` is 0.
- R2: Bit index i (0..31) is register position 31-i, and field f occupies positions 31-4f..28-4f. Field 0 is therefore `cr_o[31:28]` and field 7 is `cr_o[3:0]`.
- R3: Op 1 (signed compare) treats `opa_i` and `opb_i` as two's complement. It writes field `bf_i` as {lt, gt, eq, so_i}, with lt in the field's most significant bit. Exactly one of lt, gt and eq is set.
- R4: Op 2 (unsigned compare) writes the same field layout as R3, but compares the operands as unsigned numbers.
- R5: Op 3 (bit logic) writes bit `bt_i` with f(bit `ba_i`, bit `bb_i`) and leaves every other bit unchanged. The `lfn_i` codes are: 257 AND, 449 OR, 255 NAND, 193 XOR, 33 NOR, 289 EQV, 129 x AND NOT y, 417 x OR NOT y.
- R6: Op 3 with any other `lfn_i` code leaves `cr_o` unchanged and sets no bit of `wr_fields_o`.
- R7: Op 4 (field move) copies field `bfa_i` into field `bf_i`. All other fields keep their values.
- R8: Op 5 (masked write) works per nibble. Where `fxm_i[i]` is 1, register positions 4i+3..4i take `opa_i[4i+3:4i]`. Where it is 0, those positions keep their old values.
- R9: Op 6 (store-conditional outcome) sets field 0 to {0, 0, `stc_ok_i`, `so_i`}. This gives 0x2 when the store was performed, ORed with the summary-overflow bit. Fields 1..7 are unchanged.
- R10: Op 0 (idle) and op 7 (unassigned) leave `cr_o` unchanged.
- R11: After each edge, `wr_fields_o[f]` is 1 exactly when field f was written by that edge's update. For a masked write this is `wr_fields_o[7-i] = fxm_i[i]`.
- R12: An update becomes visible on `cr_o` after the clock edge that samples it. The next cycle's operation reads the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 idle, 1 signed cmp, 2 unsigned cmp, 3 bit logic, 4 field move, 5 masked write, 6 store-conditional |
| opa_i | input | 32 | First compare operand; source value for the masked write |
| opb_i | input | 32 | Second compare operand |
| bf_i | input | 3 | Destination field index |
| bfa_i | input | 3 | Source field index for a field move |
| ba_i | input | 5 | First source bit index for bit logic |
| bb_i | input | 5 | Second source bit index for bit logic |
| bt_i | input | 5 | Destination bit index for bit logic |
| lfn_i | input | 10 | Bit-logic function code |
| fxm_i | input | 8 | Nibble mask for the masked write |
| so_i | input | 1 | Current summary-overflow bit |
| stc_ok_i | input | 1 | Store-conditional was performed |
| cr_o | output | 32 | Full condition register value |
| wr_fields_o | output | 8 | Fields written by the previous edge, bit f for field f |

## Verification
On every cycle, the assertions check the following relations between consecutive cycles:
- an idle op holds the register and reports no written field;
- a compare leaves exactly one of lt, gt and eq set, with the overflow copy in the field's last bit;
- a field move reproduces the source field;
- a masked write merges exactly the selected nibbles;
- a store-conditional writes field 0 and touches nothing else.

Only the bench scenarios can show the rest, because it needs chosen operand values and known prior register contents:
- that each of the eight bit-logic codes computes the right function;
- that unknown codes change nothing;
- the signed versus unsigned ordering at the 0x80000000 boundary;
- that a back-to-back operation reads the value just written.

// File: rtl/crf_pkg.sv
package crf_pkg;

    parameter int CR_NFIELD = 8;
    parameter int CR_FW     = 4;
    localparam int CR_W     = CR_NFIELD * CR_FW;
    localparam int CR_FIW   = $clog2(CR_NFIELD);
    localparam int CR_BIW   = $clog2(CR_W);
    localparam int CR_FWB   = $clog2(CR_FW);
    localparam int CR_OPW   = 3;
    localparam int CR_LFW   = 10;

    typedef enum logic [CR_OPW-1:0] {
        OP_NOP   = 3'd0,
        OP_CMPS  = 3'd1,
        OP_CMPU  = 3'd2,
        OP_BITOP = 3'd3,
        OP_FMOVE = 3'd4,
        OP_MASKW = 3'd5,
        OP_STC   = 3'd6
    } cr_op_e;

    localparam logic [CR_LFW-1:0] LF_AND  = 10'd257;
    localparam logic [CR_LFW-1:0] LF_OR   = 10'd449;
    localparam logic [CR_LFW-1:0] LF_NAND = 10'd255;
    localparam logic [CR_LFW-1:0] LF_XOR  = 10'd193;
    localparam logic [CR_LFW-1:0] LF_NOR  = 10'd33;
    localparam logic [CR_LFW-1:0] LF_EQV  = 10'd289;
    localparam logic [CR_LFW-1:0] LF_ANDC = 10'd129;
    localparam logic [CR_LFW-1:0] LF_ORC  = 10'd417;

    typedef struct packed {
        logic [CR_W-1:0]      cr;
        logic [CR_NFIELD-1:0] wr;
    } cr_state_t;

endpackage

// File: rtl/crf_compare.sv
module crf_compare #(
    parameter int W  = 32,
    parameter int FW = 4
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          signed_i,
    input  logic          so_i,
    output logic [FW-1:0] field_o
);
    logic lt, eq, gt;

    always_comb begin
        eq = (a_i == b_i);
        if (signed_i) lt = ($signed(a_i) < $signed(b_i));
        else          lt = (a_i < b_i);
        gt = !lt && !eq;
        field_o = '0;
        field_o[FW-1] = lt;
        field_o[FW-2] = gt;
        field_o[FW-3] = eq;
        field_o[0]    = so_i;
    end
endmodule

// File: rtl/crf_bitlogic.sv
module crf_bitlogic
    import crf_pkg::*;
(
    input  logic [CR_LFW-1:0] code_i,
    input  logic              x_i,
    input  logic              y_i,
    output logic              res_o,
    output logic              known_o
);
    always_comb begin
        known_o = 1'b1;
        res_o   = 1'b0;
        case (code_i)
            LF_AND:  res_o = x_i & y_i;
            LF_OR:   res_o = x_i | y_i;
            LF_NAND: res_o = ~(x_i & y_i);
            LF_XOR:  res_o = x_i ^ y_i;
            LF_NOR:  res_o = ~(x_i | y_i);
            LF_EQV:  res_o = ~(x_i ^ y_i);
            LF_ANDC: res_o = x_i & ~y_i;
            LF_ORC:  res_o = x_i | ~y_i;
            default: known_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/crf_nibble_mask.sv
module crf_nibble_mask #(
    parameter int NFIELD = 8,
    parameter int FW     = 4
) (
    input  logic [NFIELD-1:0]    sel_i,
    output logic [NFIELD*FW-1:0] mask_o
);
    for (genvar g = 0; g < NFIELD; g++) begin : g_nib
        assign mask_o[g*FW +: FW] = {FW{sel_i[g]}};
    end
endmodule

// File: rtl/crf_unit.sv
module crf_unit
    import crf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CR_OPW-1:0]    op_i,
    input  logic [CR_W-1:0]      opa_i,
    input  logic [CR_W-1:0]      opb_i,
    input  logic [CR_FIW-1:0]    bf_i,
    input  logic [CR_FIW-1:0]    bfa_i,
    input  logic [CR_BIW-1:0]    ba_i,
    input  logic [CR_BIW-1:0]    bb_i,
    input  logic [CR_BIW-1:0]    bt_i,
    input  logic [CR_LFW-1:0]    lfn_i,
    input  logic [CR_NFIELD-1:0] fxm_i,
    input  logic                 so_i,
    input  logic                 stc_ok_i,
    output logic [CR_W-1:0]      cr_o,
    output logic [CR_NFIELD-1:0] wr_fields_o
);
    cr_state_t st_d, st_q;

    logic [CR_FW-1:0] cmp_field;
    logic             bit_x, bit_y, bit_res, bit_known;
    logic [CR_W-1:0]  nib_mask;

    // Big-endian bit fetch: index i lives at position W-1-i
    assign bit_x = st_q.cr[CR_W-1-int'(ba_i)];
    assign bit_y = st_q.cr[CR_W-1-int'(bb_i)];

    crf_compare #(.W(CR_W), .FW(CR_FW)) u_cmp (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .signed_i (op_i == OP_CMPS),
        .so_i     (so_i),
        .field_o  (cmp_field)
    );

    crf_bitlogic u_blog (
        .code_i  (lfn_i),
        .x_i     (bit_x),
        .y_i     (bit_y),
        .res_o   (bit_res),
        .known_o (bit_known)
    );

    crf_nibble_mask #(.NFIELD(CR_NFIELD), .FW(CR_FW)) u_mask (
        .sel_i  (fxm_i),
        .mask_o (nib_mask)
    );

    always_comb begin
        int dst_lo;
        int src_lo;
        dst_lo = (CR_NFIELD - 1 - int'(bf_i)) * CR_FW;
        src_lo = (CR_NFIELD - 1 - int'(bfa_i)) * CR_FW;
        st_d    = st_q;
        st_d.wr = '0;
        case (op_i)
            OP_CMPS, OP_CMPU: begin
                st_d.cr[dst_lo +: CR_FW] = cmp_field;
                st_d.wr[bf_i]            = 1'b1;
            end
            OP_BITOP: begin
                if (bit_known) begin
                    st_d.cr[CR_W-1-int'(bt_i)]     = bit_res;
                    st_d.wr[bt_i[CR_BIW-1:CR_FWB]] = 1'b1;
                end
            end
            OP_FMOVE: begin
                st_d.cr[dst_lo +: CR_FW] = st_q.cr[src_lo +: CR_FW];
                st_d.wr[bf_i]            = 1'b1;
            end
            OP_MASKW: begin
                st_d.cr = (opa_i & nib_mask) | (st_q.cr & ~nib_mask);
                for (int i = 0; i < CR_NFIELD; i++) begin
                    st_d.wr[CR_NFIELD-1-i] = fxm_i[i];
                end
            end
            OP_STC: begin
                st_d.cr[CR_W-1 -: CR_FW] = {{(CR_FW-2){1'b0}}, stc_ok_i, so_i};
                st_d.wr[0]               = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cr_o        = st_q.cr;
    assign wr_fields_o = st_q.wr;

endmodule

// File: rtl/crf_unit_chk.sv
module crf_unit_chk
    import crf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [CR_OPW-1:0]    op_i,
    input logic [CR_W-1:0]      opa_i,
    input logic [CR_W-1:0]      opb_i,
    input logic [CR_FIW-1:0]    bf_i,
    input logic [CR_FIW-1:0]    bfa_i,
    input logic [CR_BIW-1:0]    ba_i,
    input logic [CR_BIW-1:0]    bb_i,
    input logic [CR_BIW-1:0]    bt_i,
    input logic [CR_LFW-1:0]    lfn_i,
    input logic [CR_NFIELD-1:0] fxm_i,
    input logic                 so_i,
    input logic                 stc_ok_i,
    input logic [CR_W-1:0]      cr_o,
    input logic [CR_NFIELD-1:0] wr_fields_o
);
    function automatic logic [CR_FW-1:0] fld(logic [CR_W-1:0] v, logic [CR_FIW-1:0] f);
        return v[(CR_NFIELD-1-int'(f))*CR_FW +: CR_FW];
    endfunction

    function automatic logic [CR_W-1:0] xmask(logic [CR_NFIELD-1:0] m);
        logic [CR_W-1:0] r;
        r = '0;
        for (int i = 0; i < CR_NFIELD; i++) if (m[i]) r[i*CR_FW +: CR_FW] = '1;
        return r;
    endfunction

    // R10
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i == 3'd7) |=> ($stable(cr_o) && wr_fields_o == '0));

    // R3
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMPS || op_i == OP_CMPU) |=>
        ($countones(fld(cr_o, $past(bf_i)) & 4'hE) == 1 &&
         fld(cr_o, $past(bf_i))[0] == $past(so_i)));

    // R7
    fmove_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_FMOVE) |=> (fld(cr_o, $past(bf_i)) == fld($past(cr_o), $past(bfa_i))));

    // R8
    maskw_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MASKW) |=>
        (cr_o == (($past(opa_i) & xmask($past(fxm_i))) | ($past(cr_o) & ~xmask($past(fxm_i))))));

    // R9
    stc_field0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STC) |=>
        (cr_o[CR_W-1 -: CR_FW] == {2'b00, $past(stc_ok_i), $past(so_i)} &&
         cr_o[CR_W-CR_FW-1:0] == $past(cr_o[CR_W-CR_FW-1:0])));

    // R11
    stc_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STC) |=> (wr_fields_o == 8'h01));

endmodule

bind crf_unit crf_unit_chk u_chk (.*);

// File: tb/crf_unit_test.sv
`timescale 1ns/1ps
module crf_unit_test;
    import crf_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [CR_OPW-1:0]    op_i = '0;
    logic [CR_W-1:0]      opa_i = '0, opb_i = '0;
    logic [CR_FIW-1:0]    bf_i = '0, bfa_i = '0;
    logic [CR_BIW-1:0]    ba_i = '0, bb_i = '0, bt_i = '0;
    logic [CR_LFW-1:0]    lfn_i = '0;
    logic [CR_NFIELD-1:0] fxm_i = '0;
    logic                 so_i = 1'b0, stc_ok_i = 1'b0;
    logic [CR_W-1:0]      cr_o;
    logic [CR_NFIELD-1:0] wr_fields_o;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] exp_cr = '0;
    logic [7:0]  exp_wr = '0;

    always #2 clk = ~clk;

    crf_unit uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Reference model built from the requirement text
    task automatic model(int op, logic [31:0] a, logic [31:0] b, int bf, int bfa,
                         int ba, int bb, int bt, int lfn, logic [7:0] fxm,
                         logic so, logic ok);
        logic lt, gt, eq, x, y, r, known;
        exp_wr = '0;
        case (op)
            1, 2: begin
                lt = (op == 1) ? ($signed(a) < $signed(b)) : (a < b);
                eq = (a == b);
                gt = !lt && !eq;
                exp_cr[31-4*bf -: 4] = {lt, gt, eq, so};
                exp_wr[bf] = 1'b1;
            end
            3: begin
                x = exp_cr[31-ba]; y = exp_cr[31-bb]; known = 1'b1; r = 1'b0;
                case (lfn)
                    257: r = x & y;
                    449: r = x | y;
                    255: r = !(x & y);
                    193: r = x ^ y;
                    33:  r = !(x | y);
                    289: r = (x == y);
                    129: r = x & !y;
                    417: r = x | !y;
                    default: known = 1'b0;
                endcase
                if (known) begin
                    exp_cr[31-bt] = r;
                    exp_wr[bt/4] = 1'b1;
                end
            end
            4: begin
                exp_cr[31-4*bf -: 4] = exp_cr[31-4*bfa -: 4];
                exp_wr[bf] = 1'b1;
            end
            5: for (int i = 0; i < 8; i++) begin
                if (fxm[i]) exp_cr[4*i +: 4] = a[4*i +: 4];
                exp_wr[7-i] = fxm[i];
            end
            6: begin
                exp_cr[31:28] = {2'b00, ok, so};
                exp_wr[0] = 1'b1;
            end
            default: ;
        endcase
    endtask

    // Drive at a falling edge; the result is visible at the next falling edge
    task automatic issue(string req, int op, logic [31:0] a, logic [31:0] b,
                         int bf, int bfa, int ba, int bb, int bt, int lfn,
                         logic [7:0] fxm, logic so, logic ok);
        op_i = op[2:0]; opa_i = a; opb_i = b;
        bf_i = bf[2:0]; bfa_i = bfa[2:0];
        ba_i = ba[4:0]; bb_i = bb[4:0]; bt_i = bt[4:0];
        lfn_i = lfn[9:0]; fxm_i = fxm; so_i = so; stc_ok_i = ok;
        model(op, a, b, bf, bfa, ba, bb, bt, lfn, fxm, so, ok);
        @(negedge clk);
        chk({req, " cr"}, cr_o, exp_cr);
        chk({req, " wr"}, {24'd0, wr_fields_o}, {24'd0, exp_wr});
    endtask

    task automatic t_reset;
        chk("R1 cr", cr_o, 32'h0);
        chk("R1 wr", {24'd0, wr_fields_o}, 32'h0);
    endtask

    task automatic t_maskw;
        issue("R8", 5, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 0);
        issue("R8", 5, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 8'b0000_0101, 0, 0);
        chk("R8 literal", cr_o, 32'hFFFF_F6F8);
        chk("R11 literal", {24'd0, wr_fields_o}, 32'h0000_00A0);
        issue("R8", 5, 32'h0, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 0);
    endtask

    task automatic t_bitmap;
        issue("R2", 5, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 0, 8'h80, 0, 0);
        issue("R2", 3, 0, 0, 0, 0, 0, 0, 31, 449, 8'h0, 0, 0);
        chk("R2 literal", cr_o, 32'h8000_0001);
        chk("R12 literal", {24'd0, wr_fields_o}, 32'h0000_0080);
    endtask

    task automatic t_cmp;
        issue("R3", 1, 32'hFFFF_FFFF, 32'h1, 2, 0, 0, 0, 0, 0, 8'h0, 1, 0);
        chk("R3 literal", cr_o & 32'h00F0_0000, 32'h0090_0000);
        issue("R4", 2, 32'hFFFF_FFFF, 32'h1, 3, 0, 0, 0, 0, 0, 8'h0, 0, 0);
        chk("R4 literal", cr_o & 32'h000F_0000, 32'h0004_0000);
        issue("R3", 1, 32'h8000_0000, 32'h7FFF_FFFF, 4, 0, 0, 0, 0, 0, 8'h0, 0, 0);
        issue("R4", 2, 32'h8000_0000, 32'h7FFF_FFFF, 5, 0, 0, 0, 0, 0, 8'h0, 1, 0);
        issue("R3", 1, 32'h1234_0000, 32'h1234_0000, 0, 0, 0, 0, 0, 0, 8'h0, 0, 0);
        issue("R4", 2, 32'h5, 32'h9, 7, 0, 0, 0, 0, 0, 8'h0, 1, 0);
    endtask

    task automatic t_logic;
        int codes[8] = '{257, 449, 255, 193, 33, 289, 129, 417};
        issue("R5", 5, 32'hA5C3_3C5A, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 0);
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 4; p++) begin
                issue("R5", 3, 0, 0, 0, 0, (k*4+p) % 32, (p*9+3) % 32,
                      (k*5+p*7+1) % 32, codes[k], 8'h0, 0, 0);
            end
        end
        issue("R5", 3, 0, 0, 0, 0, 6, 6, 6, 255, 8'h0, 0, 0);
        issue("R6", 3, 0, 0, 0, 0, 1, 2, 3, 0, 8'h0, 0, 0);
        issue("R6", 3, 0, 0, 0, 0, 1, 2, 3, 258, 8'h0, 0, 0);
    endtask

    task automatic t_move;
        issue("R7", 4, 0, 0, 6, 2, 0, 0, 0, 0, 8'h0, 0, 0);
        issue("R7", 4, 0, 0, 0, 7, 0, 0, 0, 0, 8'h0, 0, 0);
        issue("R7", 4, 0, 0, 3, 3, 0, 0, 0, 0, 8'h0, 0, 0);
    endtask

    task automatic t_stc;
        issue("R9", 5, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 0);
        issue("R9", 6, 0, 0, 0, 0, 0, 0, 0, 0, 8'h0, 0, 1);
        chk("R9 literal", cr_o, 32'h2FFF_FFFF);
        issue("R9", 6, 0, 0, 0, 0, 0, 0, 0, 0, 8'h0, 1, 0);
        chk("R9 literal", cr_o, 32'h1FFF_FFFF);
        issue("R9", 6, 0, 0, 0, 0, 0, 0, 0, 0, 8'h0, 1, 1);
        chk("R9 literal", cr_o, 32'h3FFF_FFFF);
    endtask

    task automatic t_idle;
        issue("R10", 0, 32'hDEAD_BEEF, 32'h1, 1, 2, 3, 4, 5, 257, 8'hFF, 1, 1);
        issue("R10", 7, 32'hDEAD_BEEF, 32'h1, 1, 2, 3, 4, 5, 257, 8'hFF, 1, 1);
        chk("R10 literal", cr_o, 32'h3FFF_FFFF);
    endtask

    initial begin
        #1;
        t_reset;
        repeat (2) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_maskw;
        t_bitmap;
        t_cmp;
        t_logic;
        t_move;
        t_stc;
        t_idle;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule